// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Generator

This block produces four pulse-width-modulated outputs from a single free-running 8-bit period counter. A programmable prescaler sets how many system clocks pass between counter steps. Each channel compares its own duty byte with the counter. The result then passes through a per-channel enable and a per-channel polarity select before it reaches the pin. A runtime bit selects whether a period lasts 256 or 255 counter steps.

Software reaches the block through a synchronous 32-bit register port. The port uses one word-select bit and four byte-lane strobes. Word 0 holds the control, configuration and divisor bytes. Word 1 holds the four duty bytes. The port accepts every access in the cycle it is presented, so it never applies back-pressure. Read data appears one clock after the read strobe and holds until the next read. The four PWM outputs and their output-enable signals are plain level outputs with no handshake. Duty writes are staged, and the comparators use a new duty value only from the first step of the next period.

Top module: `pwm4_core`

## Requirements
- R1: After reset, both register words read as zero, `pwm_oe` is 0 and `pwm_out` is 0.
- R2: Word 0 carries the control byte in lane 0, the configuration byte in lane 1 and the divisor in lane 2. Lane 3 is reserved and reads as zero. Word 1 lane i carries the duty of channel i. A write changes only the lanes whose strobe bit is set.
- R3: Only bit 0 of the configuration byte is stored, so word 0 bits 15:9 always read as zero.
- R4: Control bit i (i = 0..3) enables channel i. While it is clear, `pwm_oe[i]` is 0 and `pwm_out[i]` is held at 0. While it is set, `pwm_oe[i]` is 1 from the cycle after the write.
- R5: Control bit 4+i inverts the level of channel i while that channel is enabled.
- R6: With polarity 0, an enabled channel is high while the counter is below its duty. A duty of 0 keeps the channel constantly low. A duty at or above the period length keeps it constantly high.
- R7: A divisor value N from 1 to 255 advances the counter once every N clocks. A divisor of 0 advances it once every 256 clocks.
- R8: With configuration bit 0 clear, the counter runs 0..255 and then wraps to 0. With it set, the counter runs 0..254 and then wraps to 0.
- R9: A written duty is used only from the step at which the counter wraps to 0, so a period already in progress keeps its old duty.
- R10: Read data is registered: `bus_rdata` shows the selected word in the clock after `bus_rd` is high, and holds that value otherwise.

Top module ports in list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | Word select: 0 = offsets 0x00-0x03, 1 = offsets 0x04-0x07 |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | Channel output levels |
| pwm_oe | output | 4 | Channel output enables, 1 = drive pin |

## Verification
The hardest behaviour to reach from the ports is R9, the hold of an in-flight period against a new duty. The new value must land after the old pulse has ended but while the counter is still below the new value. The stimulus waits for the falling edge of channel 0 at duty 100 and writes 200 a few clocks later. It then requires the pin to stay low for the rest of that period and expects the next full pulse to last 200 steps. A divisor of 0 is reached by switching from a short divisor at run time and timing the first pulse that follows.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  // byte lanes inside word 0
  localparam int unsigned LANE_CTRL = 0;
  localparam int unsigned LANE_CFG  = 1;
  localparam int unsigned LANE_DIV  = 2;
  // word select values
  localparam logic WORD_SETUP = 1'b0;
  localparam logic WORD_DUTY  = 1'b1;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic                     word,
  input  logic [NCH*DW-1:0]        wdata,
  input  logic [NCH-1:0]           wstrb,
  output logic [NCH*DW-1:0]        rdata,
  output logic [NCH-1:0]           ch_en,
  output logic [NCH-1:0]           ch_pol,
  output logic                     per_short,
  output logic [DW-1:0]            div,
  output logic [NCH-1:0][DW-1:0]   duty_req
);
  localparam int unsigned BW = NCH * DW;

  logic [NCH-1:0]         en_q, pol_q;
  logic                   sel_q;
  logic [DW-1:0]          div_q;
  logic [NCH-1:0][DW-1:0] duty_q;
  logic [BW-1:0]          setup_word, rd_mux, rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      sel_q <= 1'b0;
      div_q <= '0;
    end else if (wr && word == WORD_SETUP) begin
      if (wstrb[LANE_CTRL]) begin
        en_q  <= wdata[LANE_CTRL*DW +: NCH];
        pol_q <= wdata[LANE_CTRL*DW + NCH +: NCH];
      end
      if (wstrb[LANE_CFG]) sel_q <= wdata[LANE_CFG*DW];
      if (wstrb[LANE_DIV]) div_q <= wdata[LANE_DIV*DW +: DW];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_duty
    always_ff @(posedge clk) begin
      if (!rst_n)                                duty_q[g] <= '0;
      else if (wr && word == WORD_DUTY && wstrb[g]) duty_q[g] <= wdata[g*DW +: DW];
    end
  end

  always_comb begin
    setup_word = '0;
    setup_word[LANE_CTRL*DW +: NCH]       = en_q;
    setup_word[LANE_CTRL*DW + NCH +: NCH] = pol_q;
    setup_word[LANE_CFG*DW]               = sel_q;
    setup_word[LANE_DIV*DW +: DW]         = div_q;
    rd_mux = (word == WORD_DUTY) ? duty_q : setup_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata     = rdata_q;
  assign ch_en     = en_q;
  assign ch_pol    = pol_q;
  assign per_short = sel_q;
  assign div       = div_q;
  assign duty_req  = duty_q;
endmodule

// File: rtl/pwm4_timebase.sv
module pwm4_timebase #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  input  logic          per_short,
  output logic          tick,
  output logic          wrap,
  output logic [DW-1:0] cnt
);
  localparam logic [DW:0]   FULL_DIV = {1'b1, {DW{1'b0}}};
  localparam logic [DW-1:0] TOP_LONG = '1;
  localparam logic [DW-1:0] TOP_SHRT = TOP_LONG - 1'b1;

  logic [DW-1:0] pre_q, cnt_q;
  logic [DW:0]   lim;
  logic [DW-1:0] top;

  always_comb begin
    lim  = (div == '0) ? FULL_DIV : {1'b0, div};
    // >= so that a smaller divisor written mid-count ends the step at once
    tick = ({1'b0, pre_q} >= (lim - 1'b1));
    top  = per_short ? TOP_SHRT : TOP_LONG;
    wrap = tick && (cnt_q >= top);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [DW-1:0] duty_req,
  input  logic [DW-1:0] cnt,
  input  logic          en,
  input  logic          pol,
  output logic [DW-1:0] act_duty,
  output logic          pin,
  output logic          oe
);
  logic [DW-1:0] act_q;
  logic          raw;

  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= '0;
    else if (wrap) act_q <= duty_req;
  end

  always_comb begin
    raw = (cnt < act_q);
    pin = en & (raw ^ pol);
    oe  = en;
  end

  assign act_duty = act_q;
endmodule

// File: rtl/pwm4_core.sv
module pwm4_core #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [NCH*DW-1:0] bus_wdata,
  input  logic [NCH-1:0]    bus_wstrb,
  output logic [NCH*DW-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  logic [NCH-1:0]         ch_en, ch_pol;
  logic                   per_short;
  logic [DW-1:0]          div;
  logic [NCH-1:0][DW-1:0] duty_req, act_duty;
  logic                   tick, wrap;
  logic [DW-1:0]          cnt;

  pwm4_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .word(bus_word),
    .wdata(bus_wdata), .wstrb(bus_wstrb), .rdata(bus_rdata),
    .ch_en(ch_en), .ch_pol(ch_pol), .per_short(per_short), .div(div),
    .duty_req(duty_req)
  );

  pwm4_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .div(div), .per_short(per_short),
    .tick(tick), .wrap(wrap), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm4_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .duty_req(duty_req[g]),
      .cnt(cnt), .en(ch_en[g]), .pol(ch_pol[g]), .act_duty(act_duty[g]),
      .pin(pwm_out[g]), .oe(pwm_oe[g])
    );
  end
endmodule

// File: rtl/pwm4_core_chk.sv
module pwm4_core_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic                   bus_word,
  input logic [NCH-1:0]         ctrl_bits,
  input logic                   strb0,
  input logic [6:0]             cfg_hi,
  input logic [DW-1:0]          rsv_lane,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         pwm_oe,
  input logic [NCH-1:0]         ch_pol,
  input logic                   tick,
  input logic                   wrap,
  input logic                   per_short,
  input logic [DW-1:0]          cnt,
  input logic [NCH-1:0][DW-1:0] act_duty
);
  localparam logic [DW-1:0] TOP_SHRT = {{(DW-1){1'b1}}, 1'b0};

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_oe == '0 && pwm_out == '0));

  assert_cfg_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_word) |=> (cfg_hi == '0 && rsv_lane == '0));

  assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && strb0) |=> (pwm_oe == $past(ctrl_bits)));

  assert_step_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_short_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_short && cnt >= TOP_SHRT) |=> (cnt == '0));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_duty));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_oe[g] && !ch_pol[g] && act_duty[g] == '0) |-> !pwm_out[g]);
  end
endmodule

bind pwm4_core pwm4_core_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_word(bus_word), .ctrl_bits(bus_wdata[NCH-1:0]), .strb0(bus_wstrb[0]),
  .cfg_hi(bus_rdata[15:9]), .rsv_lane(bus_rdata[NCH*DW-1 -: DW]),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe), .ch_pol(ch_pol), .tick(tick),
  .wrap(wrap), .per_short(per_short), .cnt(cnt), .act_duty(act_duty)
);

// File: tb/pwm4_core_bench.sv
module pwm4_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;

  always #5 clk = ~clk;

  pwm4_core u_pwm4_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct { int high; int per; string tag; } pulse_t;
  pulse_t sb_q[$];
  int skip_cnt = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic w, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); bus_wr = 1'b1; bus_word = w; bus_wdata = d; bus_wstrb = s;
    @(negedge clk); bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic bus_read(input logic w, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_word = w;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // driver: push an expected pulse shape, wait for the monitor to consume it
  task automatic expect_pulse(input int high, input int per, input string tag);
    pulse_t it;
    it.high = high; it.per = per; it.tag = tag;
    skip_cnt = 2;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic check_const(input int ch, input logic val, input int n, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] !== val) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  // monitor: measures channel 0 pulses rise to rise
  int  cyc = 0, rise_t = 0, fall_t = 0;
  bit  have_rise = 1'b0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      have_rise = 1'b0; prev = 1'b0;
    end else begin
      cyc++;
      if (!prev && pwm_out[0]) begin
        if (have_rise && sb_q.size() > 0) begin
          if (skip_cnt > 0) skip_cnt--;
          else begin
            pulse_t it;
            it = sb_q.pop_front();
            check((fall_t - rise_t) == it.high, {it.tag, " high"}, fall_t - rise_t, it.high);
            check((cyc - rise_t) == it.per, {it.tag, " period"}, cyc - rise_t, it.per);
          end
        end
        rise_t = cyc; have_rise = 1'b1;
      end
      if (prev && !pwm_out[0]) fall_t = cyc;
      prev = pwm_out[0];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pwm_oe == 4'h0, "R1 oe", pwm_oe, 0);
    check(pwm_out == 4'h0, "R1 out", pwm_out, 0);
    bus_read(1'b0, rd); check(rd == 32'h0, "R1 word0", rd, 0);
    bus_read(1'b1, rd); check(rd == 32'h0, "R1 word1", rd, 0);

    // R2 R3 R10 map and strobes
    bus_write(1'b0, 32'hAB05FF30, 4'hF);
    bus_read(1'b0, rd); check(rd == 32'h00050130, "R2 R3 word0", rd, 32'h00050130);
    @(negedge clk); check(bus_rdata == 32'h00050130, "R10 hold", bus_rdata, 32'h00050130);
    bus_write(1'b0, 32'h00020000, 4'b0100);
    bus_read(1'b0, rd); check(rd == 32'h00020130, "R2 lane strobe", rd, 32'h00020130);
    bus_write(1'b1, 32'h11223344, 4'b0101);
    bus_read(1'b1, rd); check(rd == 32'h00220044, "R2 duty lanes", rd, 32'h00220044);

    // channel 0 enabled, 256 mode, divisor 2, duty 64
    bus_write(1'b1, 32'h00000040, 4'hF);
    bus_write(1'b0, 32'h00020001, 4'hF);
    check(pwm_oe == 4'b0001, "R4 oe", pwm_oe, 1);
    expect_pulse(128, 512, "R6 R7 div2");
    bus_write(1'b0, 32'h00030000, 4'b0100);
    expect_pulse(192, 768, "R7 div3");
    bus_write(1'b0, 32'h00020100, 4'b0110);
    expect_pulse(128, 510, "R8 short period");
    bus_write(1'b0, 32'h00000011, 4'b0001);
    expect_pulse(382, 510, "R5 inverted");
    bus_write(1'b0, 32'h00000001, 4'b0011);
    bus_write(1'b1, 32'h000000FF, 4'b0001);
    expect_pulse(510, 512, "R8 long period duty 255");
    // duty 255 in 255 mode: constant high
    bus_write(1'b0, 32'h00000100, 4'b0010);
    repeat (1200) @(negedge clk);
    check_const(0, 1'b1, 600, "R6 duty at period");
    bus_write(1'b1, 32'h00000000, 4'b0001);
    repeat (1200) @(negedge clk);
    check_const(0, 1'b0, 600, "R6 duty zero");

    // R9 shadow hold
    bus_write(1'b0, 32'h00000000, 4'b0010);
    bus_write(1'b1, 32'h00000064, 4'b0001);
    expect_pulse(200, 512, "R9 base");
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    while (pwm_out[0] !== 1'b0) @(negedge clk);
    bus_write(1'b1, 32'h000000C8, 4'b0001);
    check_const(0, 1'b0, 30, "R9 no early pulse");
    expect_pulse(400, 512, "R9 new duty");

    // R4 disable and R5 with duty 0
    bus_write(1'b1, 32'h00000000, 4'b0100);
    bus_write(1'b0, 32'h00000054, 4'b0001);
    check(pwm_oe == 4'b0100, "R4 oe mask", pwm_oe, 4'b0100);
    repeat (1200) @(negedge clk);
    check_const(0, 1'b0, 600, "R4 disabled low");
    check_const(2, 1'b1, 600, "R5 inverted zero duty");

    // R7 divisor 0 means 256
    bus_write(1'b0, 32'h00000001, 4'b0001);
    bus_write(1'b1, 32'h00000001, 4'b0001);
    repeat (1500) @(negedge clk);
    bus_write(1'b0, 32'h00000000, 4'b0100);
    while (pwm_out[0] !== 1'b0) @(negedge clk);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    hi = 0;
    while (pwm_out[0] === 1'b1) begin hi++; @(negedge clk); end
    check(hi == 256, "R7 divisor zero", hi, 256);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule